// File: doc/BRIEF.md
# USB Device State Tracker

This block holds the device-level USB state as a 3-bit code that firmware can read. Bus events from the line monitor move the state in hardware: a bus reset, a suspend detect and a resume detect. Completion pulses from the standard-request engine also move it: address assignment, and configuration selection with the selected configuration value. In software-control mode, firmware may overwrite the code directly through a write port.

Suspended is not a separate code. Bit 2 set marks the suspended group, and bits 1:0 keep the state that was active when the bus went idle, so a resume restores that state with no extra storage. Bus reset and suspend act whatever the response mode. Request completions are ignored while suspended and in states where the request is not legal.

Top module: `usb_dev_state_trk`

## Requirements
- R1: While rst_ni is low, and after it is released with no other input, state_o reads 3'b000 (Powered). The other codes are 3'b001 Default, 3'b010 Address, 3'b011 Configured and 3'b1xx Suspended.
- R2: A bus_reset_i pulse sets state_o to 3'b001 on the next clock from any state. It takes priority over every other input in the same cycle.
- R3: A suspend_i pulse without bus reset sets state_o[2] and keeps state_o[1:0] unchanged on the next clock, also when already suspended. It takes priority over every input except bus reset.
- R4: A resume_i pulse while state_o[2] is 1 clears bit 2 and keeps bits 1:0. While state_o[2] is 0, resume_i has no effect of its own.
- R5: set_addr_i moves state_o to 3'b010 from 3'b001, 3'b010 or 3'b011. It is ignored in 3'b000 and in any suspended code.
- R6: set_cfg_i with a nonzero cfg_value_i moves state_o to 3'b011 from 3'b010 or 3'b011. It is ignored in all other states.
- R7: set_cfg_i with cfg_value_i zero moves 3'b011 to 3'b010 and leaves every other state unchanged. When set_cfg_i and set_addr_i arrive together, set_cfg_i is applied.
- R8: wr_en_i with sw_mode_i high loads wr_data_i into all three bits. It ranks below bus reset, suspend and an effective resume, and above request completions. With sw_mode_i low, the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse, bus reset detected |
| suspend_i | input | 1 | One-cycle pulse, suspend detected |
| resume_i | input | 1 | One-cycle pulse, resume detected |
| set_addr_i | input | 1 | One-cycle pulse, address request completed |
| set_cfg_i | input | 1 | One-cycle pulse, configuration request completed |
| cfg_value_i | input | CFG_W | Configuration value that goes with set_cfg_i |
| sw_mode_i | input | 1 | Software-control mode select |
| wr_en_i | input | 1 | Firmware write strobe for the state field |
| wr_data_i | input | 3 | Firmware write data |
| state_o | output | 3 | Current device state code |

## Verification
The assertions assume that every input is synchronous to clk_i and that each pulse lasts one cycle. They do not assume the pulses are mutually exclusive. Each property lists the higher-priority inputs it excludes, so simultaneous events are legal stimulus. The bench uses the write port to set each of the eight codes as a start state. It then drives exactly one cycle of a single event or of a chosen combination, with all inputs changed on the falling edge. This keeps every input legal and reaches every cell of the state-by-event table, including the collision cases.

// File: rtl/usb_state_pkg.sv
package usb_state_pkg;
  localparam int unsigned STATE_W = 3;
  typedef logic [STATE_W-1:0] dev_state_t;
  localparam dev_state_t ST_POWERED    = 3'b000;
  localparam dev_state_t ST_DEFAULT    = 3'b001;
  localparam dev_state_t ST_ADDRESS    = 3'b010;
  localparam dev_state_t ST_CONFIGURED = 3'b011;
  localparam int unsigned SUSP_BIT     = 2;
endpackage

// File: rtl/usb_state_req.sv
module usb_state_req
  import usb_state_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  dev_state_t       cur_i,
  input  logic             set_addr_i,
  input  logic             set_cfg_i,
  input  logic [CFG_W-1:0] cfg_value_i,
  output logic             hit_o,
  output dev_state_t       tgt_o
);
  logic cfg_zero;
  assign cfg_zero = (cfg_value_i == '0);

  always_comb begin
    hit_o = 1'b0;
    tgt_o = cur_i;
    if (!cur_i[SUSP_BIT]) begin
      if (set_cfg_i) begin
        // configuration completion wins over a same-cycle address completion
        if (!cfg_zero && (cur_i == ST_ADDRESS || cur_i == ST_CONFIGURED)) begin
          hit_o = 1'b1;
          tgt_o = ST_CONFIGURED;
        end else if (cfg_zero && cur_i == ST_CONFIGURED) begin
          hit_o = 1'b1;
          tgt_o = ST_ADDRESS;
        end
      end else if (set_addr_i && cur_i != ST_POWERED) begin
        hit_o = 1'b1;
        tgt_o = ST_ADDRESS;
      end
    end
  end
endmodule

// File: rtl/usb_state_arb.sv
module usb_state_arb
  import usb_state_pkg::*;
(
  input  dev_state_t cur_i,
  input  logic       bus_reset_i,
  input  logic       suspend_i,
  input  logic       resume_i,
  input  logic       sw_wr_i,
  input  dev_state_t wr_data_i,
  input  logic       req_hit_i,
  input  dev_state_t req_tgt_i,
  output dev_state_t nxt_o
);
  always_comb begin
    if (bus_reset_i)                      nxt_o = ST_DEFAULT;
    else if (suspend_i)                   nxt_o = {1'b1, cur_i[1:0]};
    else if (resume_i && cur_i[SUSP_BIT]) nxt_o = {1'b0, cur_i[1:0]};
    else if (sw_wr_i)                     nxt_o = wr_data_i;
    else if (req_hit_i)                   nxt_o = req_tgt_i;
    else                                  nxt_o = cur_i;
  end
endmodule

// File: rtl/usb_dev_state_trk.sv
module usb_dev_state_trk
  import usb_state_pkg::*;
#(
  parameter int unsigned CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_reset_i,
  input  logic             suspend_i,
  input  logic             resume_i,
  input  logic             set_addr_i,
  input  logic             set_cfg_i,
  input  logic [CFG_W-1:0] cfg_value_i,
  input  logic             sw_mode_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_data_i,
  output logic [2:0]       state_o
);
  dev_state_t state_q, state_d, req_tgt;
  logic req_hit, sw_wr;

  assign sw_wr = wr_en_i & sw_mode_i;

  usb_state_req #(.CFG_W(CFG_W)) u_req (
    .cur_i       (state_q),
    .set_addr_i  (set_addr_i),
    .set_cfg_i   (set_cfg_i),
    .cfg_value_i (cfg_value_i),
    .hit_o       (req_hit),
    .tgt_o       (req_tgt)
  );

  usb_state_arb u_arb (
    .cur_i       (state_q),
    .bus_reset_i (bus_reset_i),
    .suspend_i   (suspend_i),
    .resume_i    (resume_i),
    .sw_wr_i     (sw_wr),
    .wr_data_i   (wr_data_i),
    .req_hit_i   (req_hit),
    .req_tgt_i   (req_tgt),
    .nxt_o       (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_POWERED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  AST_RESET_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_reset_i |=> state_o == ST_DEFAULT); // R2
  AST_SUSPEND_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspend_i && !bus_reset_i |=> state_o[2] && state_o[1:0] == $past(state_o[1:0])); // R3
  AST_RESUME_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_i && state_o[2] && !bus_reset_i && !suspend_i
    |=> state_o == {1'b0, $past(state_o[1:0])}); // R4
  AST_ADDR_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_addr_i && !set_cfg_i && state_o == ST_POWERED && !bus_reset_i && !suspend_i && !resume_i && !(wr_en_i && sw_mode_i)
    |=> state_o == ST_POWERED); // R5
  AST_CFG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_cfg_i && cfg_value_i == '0 && state_o == ST_CONFIGURED && !bus_reset_i && !suspend_i && !(wr_en_i && sw_mode_i)
    |=> state_o == ST_ADDRESS); // R7
  AST_WRITE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_mode_i && !bus_reset_i && !suspend_i && !resume_i && !set_addr_i && !set_cfg_i
    |=> $stable(state_o)); // R8
endmodule

// File: tb/usb_dev_state_trk_test.sv
module usb_dev_state_trk_test;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_reset, suspend, resume, set_addr, set_cfg, sw_mode, wr_en;
  logic [CFG_W-1:0] cfg_value;
  logic [2:0] wr_data, state;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_dev_state_trk #(.CFG_W(CFG_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bus_reset_i(bus_reset), .suspend_i(suspend),
    .resume_i(resume), .set_addr_i(set_addr), .set_cfg_i(set_cfg),
    .cfg_value_i(cfg_value), .sw_mode_i(sw_mode), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .state_o(state)
  );

  function automatic logic [2:0] model(input logic [2:0] s, input logic rs, input logic su,
      input logic re, input logic we, input logic sw, input logic [2:0] wd,
      input logic sa, input logic sc, input logic [CFG_W-1:0] cv);
    if (rs) return 3'b001;
    if (su) return {1'b1, s[1:0]};
    if (re && s[2]) return {1'b0, s[1:0]};
    if (we && sw) return wd;
    if (s[2]) return s;
    if (sc) begin
      if (cv != 0 && (s == 3'b010 || s == 3'b011)) return 3'b011;
      if (cv == 0 && s == 3'b011) return 3'b010;
      return s;
    end
    if (sa && s != 3'b000) return 3'b010;
    return s;
  endfunction

  task automatic idle();
    bus_reset = 0; suspend = 0; resume = 0; set_addr = 0; set_cfg = 0;
    sw_mode = 0; wr_en = 0; wr_data = 0; cfg_value = 0;
  endtask

  task automatic check(input string req, input logic [2:0] exp);
    n_chk++;
    if (state !== exp) begin
      n_bad++;
      $display("FAIL %s: state_o=%b expected %b", req, state, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  task automatic preload(input logic [2:0] s);
    sw_mode = 1; wr_en = 1; wr_data = s;
    step();
    check("R8", s);
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: state_o=%b expected finish", state);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle();
    #(CLK_PERIOD*2);
    check("R1", 3'b000);
    @(negedge clk); rst_ni = 1;
    step();
    check("R1", 3'b000);
    for (int s = 0; s < 8; s++) begin
      for (int ev = 0; ev < 13; ev++) begin
        logic [2:0] st, exp;
        string tag;
        st = 3'(s);
        preload(st);
        case (ev)
          0:  begin bus_reset = 1; tag = "R2"; end
          1:  begin suspend = 1; tag = "R3"; end
          2:  begin resume = 1; tag = "R4"; end
          3:  begin set_addr = 1; tag = "R5"; end
          4:  begin set_cfg = 1; cfg_value = 8'h5A; tag = "R6"; end
          5:  begin set_cfg = 1; cfg_value = 0; tag = "R7"; end
          6:  begin wr_en = 1; sw_mode = 1; wr_data = ~st; tag = "R8"; end
          7:  begin wr_en = 1; sw_mode = 0; wr_data = ~st; tag = "R8"; end
          8:  begin bus_reset = 1; suspend = 1; resume = 1; wr_en = 1; sw_mode = 1; wr_data = 3'b110; tag = "R2"; end
          9:  begin suspend = 1; resume = 1; wr_en = 1; sw_mode = 1; wr_data = ~st; tag = "R3"; end
          10: begin resume = 1; wr_en = 1; sw_mode = 1; wr_data = ~st; tag = "R4"; end
          11: begin set_addr = 1; set_cfg = 1; cfg_value = 8'h01; tag = "R7"; end
          default: begin set_addr = 1; wr_en = 1; sw_mode = 1; wr_data = 3'b000; tag = "R8"; end
        endcase
        exp = model(st, bus_reset, suspend, resume, wr_en, sw_mode, wr_data,
                    set_addr, set_cfg, cfg_value);
        step();
        check(tag, exp);
      end
    end
    // suspend then resume from each active state (R3, R4)
    for (int s = 0; s < 4; s++) begin
      preload(3'(s));
      suspend = 1; step(); check("R3", {1'b1, 2'(s)});
      set_addr = 1; step(); check("R5", {1'b1, 2'(s)});
      resume = 1; step(); check("R4", {1'b0, 2'(s)});
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule